// File: doc/BRIEF.md
# Floating-Point Overflow Detection Unit

This unit decides whether a rounded floating-point intermediate result has overflowed. It sits after the underflow test and the rounding step, and before the result is stored. Each result arrives with a signed intermediate exponent and a small set of qualifiers:

- where the result will be written: floating-point register, memory or integer register;
- the format of that destination;
- the rounding precision held in the control register;
- an optional precision forced by the instruction itself.

From these the unit picks one effective rounding precision. It then compares the exponent against that precision's largest biased exponent. A result may fit comfortably in extended format and still overflow when a narrower precision is selected.

Overflow cannot be masked. Every overflowing result raises a one-cycle exception request and sets a sticky overflow bit in the status exception byte. Only the status write port changes that bit otherwise. The unit also tells the store stage how to handle the write:

- For a floating-point register destination, the register write is suppressed.
- For a memory or integer register destination, the write goes ahead with undefined data and the exception is flagged as post-instruction.

When the destination format is not a floating format, an out-of-range result is reported as an operand error, not as an overflow. All outputs are registered, one cycle after an accepted input.

Top module: `fpov_unit`

## Requirements
- R1: `inReady` is low in reset and high from the first clock edge after reset. `outValid` is high for exactly one cycle following each cycle with `inValid` and `inReady` high, and is low otherwise. `ovfFlag`, `operr`, `wrSuppress`, `postInstr` and `excReq` are low in every cycle where `outValid` is low.
- R2: `inExp` is a 17-bit two's complement exponent. Overflow is flagged when `inExp` is greater than or equal to the limit of the effective precision. The limits are 255 for single, 2047 for double and 32767 for extended. Negative exponents never overflow.
- R3: Precision codes are 0 extended, 1 single, 2 double, and 3 treated as extended. The effective precision is chosen as follows:
  - When `forceValid` is high, `forcePrec` wins.
  - Otherwise a memory or integer destination uses `destFmt[1:0]`.
  - Otherwise `ctlPrec` is used.
- R4: Destination kinds are 0 floating-point register, 1 memory, 2 integer register, and 3 treated as memory. `destFmt` values 0, 1 and 2 are extended, single and double. Values 3 to 7 are non-floating. For a memory or integer destination with a non-floating format, an exponent of 32767 or more sets `operr` and never `ovfFlag`, whatever the forced precision.
- R5: For a floating-point register destination, `destFmt` has no effect on the result.
- R6: On overflow, `wrSuppress` is high for a floating-point register destination. `postInstr` is high for a memory or integer destination. Both are low when there is no overflow.
- R7: `excReq` is high in exactly the output cycles where `ovfFlag` is high. Overflow has no mask.
- R8: `statOvf` is set in the same cycle `ovfFlag` is presented and otherwise holds its value. A `statWrEn` cycle loads `statWrData` at the next edge, unless an overflow is presented at that same edge, in which case the bit is set.
- R9: In reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Intermediate result present |
| inReady | output | 1 | Unit accepts results |
| inExp | input | 17 | Signed intermediate exponent |
| destKind | input | 2 | Destination kind code |
| destFmt | input | 3 | Destination format code |
| ctlPrec | input | 2 | Control-register rounding precision |
| forceValid | input | 1 | Instruction forces a precision |
| forcePrec | input | 2 | Forced precision code |
| statWrEn | input | 1 | Status overflow bit write strobe |
| statWrData | input | 1 | Value written to the status overflow bit |
| outValid | output | 1 | Registered result valid |
| ovfFlag | output | 1 | Overflow detected |
| operr | output | 1 | Operand error instead of overflow |
| wrSuppress | output | 1 | Destination register write suppressed |
| postInstr | output | 1 | Exception reported as post-instruction |
| excReq | output | 1 | Nonmaskable overflow exception request pulse |
| statOvf | output | 1 | Sticky overflow bit of the status exception byte |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before any result is offered. They also assume `inValid` is only acted on once `inReady` is high, so a value offered during reset is never expected to appear at the output. The stimulus keeps reset low for several cycles and raises `inValid` only after `inReady` has been seen high. Every code of kind, format and precision, including the reserved ones, is then swept against exponents on both sides of each limit and at both ends of the signed range.

// File: rtl/fpov_pkg.sv
`timescale 1ns/1ps
package fpov_pkg;

  typedef enum logic [1:0] {
    PREC_EXT = 2'd0,
    PREC_SGL = 2'd1,
    PREC_DBL = 2'd2,
    PREC_RSV = 2'd3
  } prec_e;

  typedef enum logic [1:0] {
    DK_FPREG = 2'd0,
    DK_MEM   = 2'd1,
    DK_INT   = 2'd2,
    DK_RSV   = 2'd3
  } destKind_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;    // capture a result this cycle
    logic wrStat;  // status bit write
    logic wrVal;   // value for the status bit
  } dpStrobe_t;

  localparam int SGL_MAX_EXP = 255;
  localparam int DBL_MAX_EXP = 2047;
  localparam int EXT_MAX_EXP = 32767;

endpackage

// File: rtl/fpov_ctrl.sv
`timescale 1ns/1ps
module fpov_ctrl
  import fpov_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      statWrEn,
  input  logic      statWrData,
  input  logic      ovfHit,
  output dpStrobe_t strobe,
  output logic      inReady,
  output logic      outValid,
  output logic      excReq
);

  logic readyQ;
  logic takeIn;

  assign takeIn  = inValid & readyQ;
  assign inReady = readyQ;

  always_comb begin
    strobe.load   = takeIn;
    strobe.wrStat = statWrEn;
    strobe.wrVal  = statWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      outValid <= 1'b0;
      excReq   <= 1'b0;
    end else begin
      readyQ   <= 1'b1;
      outValid <= takeIn;
      excReq   <= takeIn & ovfHit;
    end
  end

endmodule

// File: rtl/fpov_dp.sv
`timescale 1ns/1ps
module fpov_dp
  import fpov_pkg::*;
#(
  parameter int EXP_W     = 17,
  parameter int SGL_LIMIT = SGL_MAX_EXP,
  parameter int DBL_LIMIT = DBL_MAX_EXP,
  parameter int EXT_LIMIT = EXT_MAX_EXP
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [EXP_W-1:0] inExp,
  input  logic [1:0]       destKind,
  input  logic [2:0]       destFmt,
  input  logic [1:0]       ctlPrec,
  input  logic             forceValid,
  input  logic [1:0]       forcePrec,
  output logic             ovfHit,
  output logic             ovfFlag,
  output logic             operr,
  output logic             wrSuppress,
  output logic             postInstr,
  output logic             statOvf
);

  localparam logic signed [EXP_W-1:0] LIM_SGL = EXP_W'(SGL_LIMIT);
  localparam logic signed [EXP_W-1:0] LIM_DBL = EXP_W'(DBL_LIMIT);
  localparam logic signed [EXP_W-1:0] LIM_EXT = EXP_W'(EXT_LIMIT);

  logic                    memLike;
  logic                    floatFmt;
  prec_e                   effPrec;
  logic signed [EXP_W-1:0] limitSel;
  logic                    overLimit;
  logic                    operrHit;

  assign memLike  = (destKind != DK_FPREG);
  assign floatFmt = (destFmt <= 3'd2);

  // Precision priority: forced, then destination format, then control register
  always_comb begin
    if (forceValid)   effPrec = prec_e'(forcePrec);
    else if (memLike) effPrec = prec_e'(destFmt[1:0]);
    else              effPrec = prec_e'(ctlPrec);
    if (memLike && !floatFmt) effPrec = PREC_EXT;
  end

  always_comb begin
    unique case (effPrec)
      PREC_SGL: limitSel = LIM_SGL;
      PREC_DBL: limitSel = LIM_DBL;
      default:  limitSel = LIM_EXT;
    endcase
  end

  assign overLimit = ($signed(inExp) >= limitSel);
  assign ovfHit    = overLimit && !(memLike && !floatFmt);
  assign operrHit  = overLimit && memLike && !floatFmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag    <= 1'b0;
      operr      <= 1'b0;
      wrSuppress <= 1'b0;
      postInstr  <= 1'b0;
      statOvf    <= 1'b0;
    end else begin
      ovfFlag    <= strobe.load & ovfHit;
      operr      <= strobe.load & operrHit;
      wrSuppress <= strobe.load & ovfHit & !memLike;
      postInstr  <= strobe.load & ovfHit & memLike;
      if (strobe.load && ovfHit) statOvf <= 1'b1;
      else if (strobe.wrStat)    statOvf <= strobe.wrVal;
    end
  end

endmodule

// File: rtl/fpov_unit.sv
`timescale 1ns/1ps
module fpov_unit
  import fpov_pkg::*;
#(
  parameter int EXP_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [EXP_W-1:0] inExp,
  input  logic [1:0]       destKind,
  input  logic [2:0]       destFmt,
  input  logic [1:0]       ctlPrec,
  input  logic             forceValid,
  input  logic [1:0]       forcePrec,
  input  logic             statWrEn,
  input  logic             statWrData,
  output logic             outValid,
  output logic             ovfFlag,
  output logic             operr,
  output logic             wrSuppress,
  output logic             postInstr,
  output logic             excReq,
  output logic             statOvf
);

  dpStrobe_t strobe;
  logic      ovfHit;

  fpov_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .statWrEn   (statWrEn),
    .statWrData (statWrData),
    .ovfHit     (ovfHit),
    .strobe     (strobe),
    .inReady    (inReady),
    .outValid   (outValid),
    .excReq     (excReq)
  );

  fpov_dp #(.EXP_W(EXP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inExp      (inExp),
    .destKind   (destKind),
    .destFmt    (destFmt),
    .ctlPrec    (ctlPrec),
    .forceValid (forceValid),
    .forcePrec  (forcePrec),
    .ovfHit     (ovfHit),
    .ovfFlag    (ovfFlag),
    .operr      (operr),
    .wrSuppress (wrSuppress),
    .postInstr  (postInstr),
    .statOvf    (statOvf)
  );

endmodule

// File: rtl/fpov_chk.sv
`timescale 1ns/1ps
module fpov_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic statWrEn,
  input logic outValid,
  input logic ovfFlag,
  input logic operr,
  input logic wrSuppress,
  input logic postInstr,
  input logic excReq,
  input logic statOvf
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid); // R1
  AST_OVF_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag || operr) |-> outValid); // R1
  AST_OVF_OR_OPERR: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && operr)); // R4
  AST_WRITE_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (wrSuppress || postInstr) |-> (ovfFlag && $onehot0({wrSuppress, postInstr}))); // R6
  AST_OVF_ROUTED: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (wrSuppress || postInstr)); // R6
  AST_EXC_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    excReq == ovfFlag); // R7
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> statOvf); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!statWrEn && statOvf) |=> statOvf); // R8

endmodule

bind fpov_unit fpov_chk u_chk (.*);

// File: tb/tb_fpov_unit.sv
`timescale 1ns/1ps
module tb_fpov_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [16:0] inExp;
  logic [1:0]  destKind;
  logic [2:0]  destFmt;
  logic [1:0]  ctlPrec;
  logic        forceValid;
  logic [1:0]  forcePrec;
  logic        statWrEn;
  logic        statWrData;
  logic        outValid, ovfFlag, operr, wrSuppress, postInstr, excReq, statOvf;

  int nTests = 0;
  int nFail  = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  fpov_unit dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int limitOf(input int p);
    if (p == 1) return 255;
    if (p == 2) return 2047;
    return 32767;
  endfunction

  function automatic void model(input int dk, input int df, input int cp,
                                input int fv, input int fp, input int e,
                                output int ovf, output int opr);
    int p;
    bit memLike = (dk != 0);
    if (memLike && df > 2) begin
      ovf = 0;
      opr = (e >= 32767) ? 1 : 0;
      return;
    end
    if (fv != 0)     p = fp;
    else if (memLike) p = df;
    else             p = cp;
    ovf = (e >= limitOf(p)) ? 1 : 0;
    opr = 0;
  endfunction

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int expList[13] = '{-65536, -5, 0, 254, 255, 256, 2046, 2047, 2048,
                        32766, 32767, 32768, 65535};
    int stickyExp = 0;
    rstN = 0; inValid = 0; inExp = '0; destKind = 0; destFmt = 0;
    ctlPrec = 0; forceValid = 0; forcePrec = 0; statWrEn = 0; statWrData = 0;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 outValid", outValid, 0);
    check("R9 ovfFlag", ovfFlag, 0);
    check("R9 statOvf", statOvf, 0);
    check("R9 excReq", excReq, 0);
    check("R1 inReady in reset", inReady, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 inReady after reset", inReady, 1);

    // Sweep every code combination against exponents around each limit
    for (int dk = 0; dk < 4; dk++)
      for (int df = 0; df < 8; df++)
        for (int cp = 0; cp < 4; cp++)
          for (int fv = 0; fv < 2; fv++)
            for (int fp = 0; fp < 4; fp++)
              for (int ei = 0; ei < 13; ei++) begin
                int eOvf, eOpr, e;
                e = expList[ei];
                inValid = 1; destKind = 2'(dk); destFmt = 3'(df); ctlPrec = 2'(cp);
                forceValid = fv[0]; forcePrec = 2'(fp); inExp = 17'(e);
                model(dk, df, cp, fv, fp, e, eOvf, eOpr);
                if (eOvf != 0) stickyExp = 1;
                @(negedge clk);
                check("R1 outValid", outValid, 1);
                if (ovfFlag != eOvf) check("R2 R3 ovfFlag", ovfFlag, eOvf);
                if (operr != eOpr) check("R4 operr", operr, eOpr);
                if (wrSuppress != ((dk == 0) ? eOvf : 0))
                  check("R6 wrSuppress", wrSuppress, (dk == 0) ? eOvf : 0);
                if (postInstr != ((dk != 0) ? eOvf : 0))
                  check("R6 postInstr", postInstr, (dk != 0) ? eOvf : 0);
                if (excReq != eOvf) check("R7 excReq", excReq, eOvf);
                if (statOvf != stickyExp) check("R8 statOvf", statOvf, stickyExp);
              end

    // R2 boundary: single limit through forced precision
    inValid = 1; destKind = 0; destFmt = 0; ctlPrec = 0; forceValid = 1; forcePrec = 1;
    inExp = 17'd254;
    @(negedge clk); check("R2 single 254 no overflow", ovfFlag, 0);
    inExp = 17'd255;
    @(negedge clk); check("R2 single 255 overflow", ovfFlag, 1);
    // R3 force beats memory destination format
    destKind = 1; destFmt = 0; forceValid = 1; forcePrec = 2; inExp = 17'd2047;
    @(negedge clk); check("R3 force double over memory extended", ovfFlag, 1);
    // R5 destination format ignored for FP register
    destKind = 0; destFmt = 1; ctlPrec = 0; forceValid = 0; inExp = 17'd300;
    @(negedge clk); check("R5 fpreg ignores destFmt", ovfFlag, 0);
    // R4 non-floating format with forced precision
    destKind = 2; destFmt = 5; forceValid = 1; forcePrec = 1; inExp = 17'd1000;
    @(negedge clk); check("R4 nonfloat below ext limit", operr, 0);
    check("R4 nonfloat no ovf", ovfFlag, 0);

    // R1 idle: nothing presented
    inValid = 0; inExp = 17'd40000; destKind = 0; forceValid = 0;
    @(negedge clk);
    check("R1 idle outValid", outValid, 0);
    check("R1 idle ovfFlag", ovfFlag, 0);
    check("R1 idle excReq", excReq, 0);

    // R8 sticky write port
    statWrEn = 1; statWrData = 0;
    @(negedge clk); check("R8 clear by write", statOvf, 0);
    statWrEn = 0;
    inValid = 1; inExp = 17'd5; destKind = 0; ctlPrec = 0;
    @(negedge clk); check("R8 hold without overflow", statOvf, 0);
    statWrEn = 1; statWrData = 0; inExp = 17'd40000;
    @(negedge clk); check("R8 set wins over clear", statOvf, 1);
    inValid = 0; statWrEn = 1; statWrData = 0;
    @(negedge clk); check("R8 clear again", statOvf, 0);
    statWrData = 1;
    @(negedge clk); check("R8 write one", statOvf, 1);
    statWrEn = 0;
    @(negedge clk); check("R8 hold one", statOvf, 1);

    finishRun();
  end

endmodule